// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Bus Engine

This block is the bit-level front end of a serial memory that sits on a two-wire bus as a slave. It samples the clock and data lines with a fast system clock and finds bus START and STOP conditions. It assembles bytes from the data line and compares the first byte after each START with a fixed selector prefix and three strap inputs. It pulls the data line low in the ninth clock to acknowledge, and it drives read bytes onto the line through an open-drain enable. The data line is only ever pulled low; it is never driven high.

A command layer sits behind the engine. The engine gives it START and STOP pulses, a select pulse with the transfer direction, and each received data byte with a one-cycle strobe. The command layer returns two things: an accept/reject decision for each written byte, and the next byte to transmit. The engine pulses a load strobe each time it consumes that byte. While the command layer reports an internal write in progress, the engine does not acknowledge its own selector. A master can therefore poll the device until the write finishes.

Top module: `twi_eeprom_front`

## Requirements
- R1: A falling data line while the clock line is high is a START. It pulses `start_o`, releases SDA and makes the engine wait for a selector byte, even in the middle of a transfer.
- R2: A rising data line while the clock line is high is a STOP. It pulses `stop_o`, releases SDA and returns the engine to idle.
- R3: The selector byte is received MSB first. Bits 7..4 must be 1010 and bits 3..1 must equal `strap_i[2:0]`. On a match, SDA is pulled low during the ninth clock. On a mismatch, SDA stays released until the next START.
- R4: While `wr_busy_i` is high when the selector byte completes, the selector is not acknowledged, `sel_o` stays low and SDA stays released.
- R5: When the selector is acknowledged, `sel_o` pulses once. `rw_o` then holds bit 0 of the selector (1 = read, 0 = write).
- R6: In a write transfer, each data byte is assembled MSB first on clock rising edges. It appears on `rx_byte_o` together with a one-cycle `rx_valid_o` pulse after the eighth rising edge.
- R7: The acknowledge of a written byte follows `ack_data_i` at the next clock falling edge: 1 pulls SDA low, 0 leaves SDA released. After a rejected byte the engine stays silent until the next START.
- R8: In a read transfer, `tx_data_i` is captured at the falling edge that ends the acknowledge slot, and `tx_load_o` pulses once. The byte is shifted out MSB first, with a 1 sent as a released line. SDA is released during the master's acknowledge slot.
- R9: In a read, an acknowledge (SDA low) from the master starts the next byte. A no-acknowledge ends output, and SDA stays released through any further clocks until the next START.
- R10: The SDA enable changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Strap levels matched against selector bits 3..1 |
| wr_busy_i | input | 1 | Internal write in progress |
| start_o | output | 1 | START seen (one cycle) |
| stop_o | output | 1 | STOP seen (one cycle) |
| sel_o | output | 1 | Selector acknowledged (one cycle) |
| rw_o | output | 1 | Direction of the current transfer, 1 = read |
| rx_byte_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | Strobe for `rx_byte_o` |
| ack_data_i | input | 1 | Accept decision for the current written byte |
| tx_data_i | input | 8 | Next byte to transmit |
| tx_load_o | output | 1 | `tx_data_i` consumed (one cycle) |

## Verification
Two functions can collide. A START condition can arrive while the engine is in the middle of a byte or is itself holding the data line in an acknowledge slot. Likewise, the busy flag can coincide with the completion of a matching selector. The bench provokes the first by issuing a repeated START straight after an acknowledged address byte. It then expects the new selector to be honoured and the following read data to match. It provokes the second by holding the busy input across randomly chosen transfers. It then judges the line level sampled in the ninth clock, and requires that no select or load strobe appears.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned STRAP_W  = 3;
  localparam int unsigned PREFIX_W = BYTE_W - STRAP_W - 1;
  localparam logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_SEL_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_RD_NEXT
  } bus_state_e;

  function automatic logic dev_match(input logic [BYTE_W-1:0] b,
                                     input logic [STRAP_W-1:0] strap);
    return (b[BYTE_W-1 -: PREFIX_W] == DEV_PREFIX) && (b[STRAP_W:1] == strap);
  endfunction
endpackage

// File: rtl/twi_sync_edge.sv
module twi_sync_edge #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] lvl_o,
  output logic [WIDTH-1:0] prev_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '1;
      else         chain <= {chain[STAGES-1:0], d_i[g]};
    end
    assign lvl_o[g]  = chain[STAGES-1];
    assign prev_o[g] = chain[STAGES];
  end
endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
  input  logic scl_lvl_i,
  input  logic scl_prev_i,
  input  logic sda_lvl_i,
  input  logic sda_prev_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_held;
  assign scl_held = scl_lvl_i & scl_prev_i;
  assign start_o  = scl_held & sda_prev_i & ~sda_lvl_i;
  assign stop_o   = scl_held & ~sda_prev_i & sda_lvl_i;
  assign rise_o   = scl_lvl_i & ~scl_prev_i;
  assign fall_o   = ~scl_lvl_i & scl_prev_i;
endmodule

// File: rtl/twi_bit_fsm.sv
module twi_bit_fsm
  import twi_eeprom_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_busy_i,
  input  logic               ack_data_i,
  input  logic [BYTE_W-1:0]  tx_data_i,
  output logic               sda_oe_o,
  output logic               sel_o,
  output logic               rw_o,
  output logic [BYTE_W-1:0]  rx_byte_o,
  output logic               rx_valid_o,
  output logic               tx_load_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  bus_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              ack_slot_q;
  logic              ack_ok_q;
  logic [BYTE_W-1:0] in_byte;

  assign in_byte = {sh_q[BYTE_W-2:0], sda_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      ack_slot_q <= 1'b0;
      ack_ok_q   <= 1'b0;
      sda_oe_o   <= 1'b0;
      sel_o      <= 1'b0;
      rw_o       <= 1'b0;
      rx_byte_o  <= '0;
      rx_valid_o <= 1'b0;
      tx_load_o  <= 1'b0;
    end else begin
      sel_o      <= 1'b0;
      rx_valid_o <= 1'b0;
      tx_load_o  <= 1'b0;
      if (start_i) begin
        state_q    <= ST_SEL;
        cnt_q      <= '0;
        ack_slot_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else if (stop_i) begin
        state_q    <= ST_IDLE;
        ack_slot_q <= 1'b0;
        sda_oe_o   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_SEL: if (rise_i) begin
            sh_q  <= in_byte;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              if (dev_match(in_byte, strap_i) && !wr_busy_i) begin
                state_q <= ST_SEL_ACK;
                rw_o    <= sda_i;
                sel_o   <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end
          end
          ST_SEL_ACK: if (fall_i) begin
            if (!ack_slot_q) begin
              sda_oe_o   <= 1'b1;
              ack_slot_q <= 1'b1;
            end else begin
              ack_slot_q <= 1'b0;
              cnt_q      <= '0;
              if (rw_o) begin
                state_q   <= ST_RD;
                sda_oe_o  <= ~tx_data_i[BYTE_W-1];
                sh_q      <= {tx_data_i[BYTE_W-2:0], 1'b0};
                tx_load_o <= 1'b1;
              end else begin
                state_q  <= ST_WR;
                sda_oe_o <= 1'b0;
              end
            end
          end
          ST_WR: if (rise_i) begin
            sh_q  <= in_byte;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              rx_byte_o  <= in_byte;
              rx_valid_o <= 1'b1;
              state_q    <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: if (fall_i) begin
            if (!ack_slot_q) begin
              sda_oe_o   <= ack_data_i;
              ack_ok_q   <= ack_data_i;
              ack_slot_q <= 1'b1;
            end else begin
              ack_slot_q <= 1'b0;
              sda_oe_o   <= 1'b0;
              cnt_q      <= '0;
              state_q    <= ack_ok_q ? ST_WR : ST_IDLE;
            end
          end
          ST_RD: begin
            if (fall_i) begin
              sda_oe_o <= ~sh_q[BYTE_W-1];
              sh_q     <= {sh_q[BYTE_W-2:0], 1'b0};
            end else if (rise_i) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == LAST_BIT) state_q <= ST_RD_ACK;
            end
          end
          ST_RD_ACK: begin
            if (fall_i) sda_oe_o <= 1'b0;
            else if (rise_i) state_q <= sda_i ? ST_IDLE : ST_RD_NEXT;
          end
          ST_RD_NEXT: if (fall_i) begin
            state_q   <= ST_RD;
            cnt_q     <= '0;
            sda_oe_o  <= ~tx_data_i[BYTE_W-1];
            sh_q      <= {tx_data_i[BYTE_W-2:0], 1'b0};
            tx_load_o <= 1'b1;
          end
          default: sda_oe_o <= 1'b0;
        endcase
      end
    end
  end
endmodule

// File: rtl/twi_eeprom_front.sv
module twi_eeprom_front
  import twi_eeprom_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               wr_busy_i,
  output logic               start_o,
  output logic               stop_o,
  output logic               sel_o,
  output logic               rw_o,
  output logic [BYTE_W-1:0]  rx_byte_o,
  output logic               rx_valid_o,
  input  logic               ack_data_i,
  input  logic [BYTE_W-1:0]  tx_data_i,
  output logic               tx_load_o
);
  logic [1:0] lvl, prev;
  logic       rise, fall;

  twi_sync_edge #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({scl_i, sda_i}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  twi_cond_detect u_cond (
    .scl_lvl_i  (lvl[1]),
    .scl_prev_i (prev[1]),
    .sda_lvl_i  (lvl[0]),
    .sda_prev_i (prev[0]),
    .start_o    (start_o),
    .stop_o     (stop_o),
    .rise_o     (rise),
    .fall_o     (fall)
  );

  twi_bit_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_o),
    .stop_i     (stop_o),
    .rise_i     (rise),
    .fall_i     (fall),
    .sda_i      (lvl[0]),
    .strap_i    (strap_i),
    .wr_busy_i  (wr_busy_i),
    .ack_data_i (ack_data_i),
    .tx_data_i  (tx_data_i),
    .sda_oe_o   (sda_oe_o),
    .sel_o      (sel_o),
    .rw_o       (rw_o),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o),
    .tx_load_o  (tx_load_o)
  );
endmodule

// File: rtl/twi_eeprom_front_chk.sv
module twi_eeprom_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wr_busy_i,
  input logic start_o,
  input logic stop_o,
  input logic sel_o,
  input logic rw_o,
  input logic rx_valid_o,
  input logic tx_load_o
);
  assert_start_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !sda_oe_o);
  assert_stop_release_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |=> !sda_oe_o);
  assert_busy_no_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |-> !wr_busy_i);
  assert_sel_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o |=> !sel_o);
  assert_rx_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  assert_load_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> (rw_o && !rx_valid_o));
  assert_oe_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i);
endmodule

bind twi_eeprom_front twi_eeprom_front_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .scl_i      (scl_i),
  .sda_oe_o   (sda_oe_o),
  .wr_busy_i  (wr_busy_i),
  .start_o    (start_o),
  .stop_o     (stop_o),
  .sel_o      (sel_o),
  .rw_o       (rw_o),
  .rx_valid_o (rx_valid_o),
  .tx_load_o  (tx_load_o)
);

// File: tb/twi_eeprom_front_tb_top.sv
module twi_eeprom_front_tb_top;
  localparam int H = 10;
  localparam logic [2:0] STRAP = 3'b101;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       wr_busy = 1'b0;
  logic       ack_data = 1'b1;
  logic [7:0] tx_data;
  logic       sda_oe, start_p, stop_p, sel_p, rw, rx_valid, tx_load;
  logic [7:0] rx_byte;
  wire        sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0;
  int n_start = 0, n_stop = 0, n_sel = 0, n_load = 0;
  int rx_n = 0;
  logic [7:0] rx_buf [0:255];
  int rd_idx = 0, exp_idx = 0;
  bit quiet = 1'b0;
  int quiet_viol = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 29 + 60) ^ 8'hA5);
  endfunction
  assign tx_data = pat(rd_idx);

  twi_eeprom_front dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .wr_busy_i(wr_busy),
    .start_o(start_p), .stop_o(stop_p), .sel_o(sel_p), .rw_o(rw),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .ack_data_i(ack_data),
    .tx_data_i(tx_data), .tx_load_o(tx_load)
  );

  always @(posedge clk) if (tx_load) rd_idx <= rd_idx + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (start_p) n_start++;
      if (stop_p) n_stop++;
      if (sel_p) n_sel++;
      if (tx_load) n_load++;
      if (rx_valid) begin rx_buf[rx_n[7:0]] = rx_byte; rx_n++; end
      if (quiet && sda_oe) quiet_viol++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(input int n = H);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    int s0;
    s0 = n_start;
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(); sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
    chk(n_start == s0 + 1, "R1 start pulse", n_start - s0, 1);
    chk(!sda_oe, "R1 released after start", sda_oe, 0);
  endtask

  task automatic bus_stop;
    int s0;
    s0 = n_stop;
    sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
    chk(n_stop == s0 + 1, "R2 stop pulse", n_stop - s0, 1);
    chk(!sda_oe, "R2 released after stop", sda_oe, 0);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; hp(); scl_m = 1'b1; hp(H / 2); b = sda_line; hp(H - H / 2); scl_m = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    acked = !b;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(!mack);
  endtask

  // selector: expect ack only on match and not busy
  task automatic do_sel(input logic [7:0] sel, input bit exp_ack, input string req);
    bit a;
    int s0;
    s0 = n_sel;
    send_byte(sel, a);
    chk(a == exp_ack, {req, " selector ack"}, a, exp_ack);
    chk((n_sel - s0) == int'(exp_ack), {req, " sel pulse"}, n_sel - s0, exp_ack);
    if (exp_ack) chk(rw == sel[0], "R5 direction", rw, sel[0]);
  endtask

  task automatic write_bytes(input int n, input bit allow_nack);
    bit a;
    logic [7:0] v;
    int r0;
    for (int i = 0; i < n; i++) begin
      v = 8'($urandom);
      ack_data = allow_nack ? 1'($urandom) : 1'b1;
      r0 = rx_n;
      send_byte(v, a);
      chk(rx_n == r0 + 1, "R6 rx strobe", rx_n - r0, 1);
      chk(rx_buf[r0[7:0]] == v, "R6 rx byte", rx_buf[r0[7:0]], v);
      chk(a == ack_data, "R7 data ack", a, ack_data);
      if (!a) break;
    end
    ack_data = 1'b1;
  endtask

  task automatic read_bytes(input int n);
    logic [7:0] v;
    int l0;
    for (int i = 0; i < n; i++) begin
      l0 = n_load;
      recv_byte(i != n - 1, v);
      chk(v == pat(exp_idx), "R8 read byte", v, pat(exp_idx));
      chk(n_load == l0 + 1, "R9 one load per byte", n_load - l0, 1);
      exp_idx++;
    end
  endtask

  task automatic quiet_clocks(input string req);
    logic b;
    quiet = 1'b1; quiet_viol = 0;
    for (int i = 0; i < 18; i++) get_bit(b);
    quiet = 1'b0;
    chk(quiet_viol == 0, req, quiet_viol, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] sel;
    int l0;
    void'($urandom(32'h1234_5678));
    hp(3);
    chk(!sda_oe && !rx_valid && !sel_p && !tx_load && !start_p && !stop_p,
        "R2 reset outputs idle", sda_oe, 0);
    rst_n = 1'b1; hp(4);

    // write, two bytes accepted
    bus_start(); do_sel({4'b1010, STRAP, 1'b0}, 1'b1, "R3"); write_bytes(2, 0); bus_stop();
    // strap mismatch: no ack, silent
    bus_start(); do_sel({4'b1010, 3'b100, 1'b0}, 1'b0, "R3"); quiet_clocks("R3 silent after mismatch"); bus_stop();
    // prefix mismatch
    bus_start(); do_sel({4'b1011, STRAP, 1'b1}, 1'b0, "R3"); quiet_clocks("R3 silent after bad prefix"); bus_stop();
    // busy: acknowledge polling
    wr_busy = 1'b1;
    bus_start(); l0 = n_load; do_sel({4'b1010, STRAP, 1'b1}, 1'b0, "R4");
    quiet_clocks("R4 silent while busy");
    chk(n_load == l0, "R4 no load while busy", n_load - l0, 0);
    bus_stop(); wr_busy = 1'b0;
    // rejected write byte
    bus_start(); do_sel({4'b1010, STRAP, 1'b0}, 1'b1, "R3");
    ack_data = 1'b0; send_byte(8'h5A, a); ack_data = 1'b1;
    chk(!a, "R7 rejected byte nack", a, 0);
    quiet_clocks("R7 silent after reject"); bus_stop();
    // read three, then silence after nack
    bus_start(); do_sel({4'b1010, STRAP, 1'b1}, 1'b1, "R5"); read_bytes(3);
    l0 = n_load; quiet_clocks("R9 silent after master nack");
    chk(n_load == l0, "R9 no load after nack", n_load - l0, 0);
    bus_stop();
    // repeated start after address byte, then read
    bus_start(); do_sel({4'b1010, STRAP, 1'b0}, 1'b1, "R1");
    send_byte(8'h12, a); chk(a, "R7 address byte ack", a, 1);
    bus_start(); do_sel({4'b1010, STRAP, 1'b1}, 1'b1, "R1 repeated start"); read_bytes(2); bus_stop();
    // repeated start mid-byte
    bus_start(); do_sel({4'b1010, STRAP, 1'b0}, 1'b1, "R1");
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_start(); do_sel({4'b1010, STRAP, 1'b0}, 1'b1, "R1 mid-byte restart"); write_bytes(1, 0); bus_stop();

    // random traffic
    for (int t = 0; t < 24; t++) begin
      logic [2:0] st;
      bit busy, rd, ok;
      int n;
      st = ($urandom % 3 == 0) ? 3'($urandom) : STRAP;
      busy = ($urandom % 4 == 0);
      rd = 1'($urandom);
      n = 1 + $urandom % 4;
      ok = (st == STRAP) && !busy;
      sel = {4'b1010, st, rd};
      wr_busy = busy;
      bus_start(); do_sel(sel, ok, busy ? "R4" : "R3");
      wr_busy = 1'b0;
      if (ok) begin
        if (rd) read_bytes(n); else write_bytes(n, 1);
      end else begin
        quiet_clocks("R3 random silence");
      end
      bus_stop();
      hp(2 * H);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule